// File: doc/BRIEF.md
# I2C Byte Shift Register

This block is the byte-wide serial data register of a multi-master I2C controller. The CPU loads a byte through one of two write strobes. The register then moves that byte out on the data line, most significant bit first, or collects an incoming byte one bit at a time. Every shift follows an edge of the serial clock, and the clock line is sampled in the bus-clock domain. A bit counter tracks the progress of the transfer and flags the end of each byte.

The data write strobe is the normal way to begin a byte. It restarts the bit counter. In master mode it also asks the clock generator to begin toggling SCL. The buffer write strobe is used before a repeated START. It places an address byte into the same register without touching the counter and without requesting SCL. Both strobes are honoured only while the enable input is high. The CPU can read back the register contents at any time, but a read through the buffer port always returns zero.

Two timing rules are watched in bus clocks, and a violation of either is flagged. After master mode is dropped, a write must wait a minimum number of cycles. A START or RESTART request must likewise wait a minimum number of cycles after a write.

Top module: `i2c_byte_shifter`

## Requirements
- R1: In transmit mode (`tx_mode_i`=1), `sda_o` shows bit 7 of the register. Each detected SCL falling edge shifts the register left by one and fills bit 0 with 0. The byte therefore leaves MSB first, and after 8 falls the register reads 0x00.
- R2: In receive mode (`tx_mode_i`=0), each detected SCL rising edge shifts the register left by one and places `sda_i` in bit 0. After 8 rises the first bit received sits in bit 7.
- R3: When `en_i`=0, a pulse on `dsr_wr_i` is ignored. The register contents, `bit_cnt_o` and `scl_go_o` all stay unchanged.
- R4: A data write with `en_i`=1 loads `wdata_i`, clears `bit_cnt_o` to 0 and arms shifting. Both changes are visible in the cycle after the strobe.
- R5: `scl_go_o` is a one-cycle pulse in the cycle after a data write made with `en_i`=1 and `mst_i`=1. In slave mode it stays 0.
- R6: With `rd_sel_i`=0, `rdata_o` returns the register contents whatever the value of `en_i`. With `rd_sel_i`=1 (the buffer port), it returns 0x00.
- R7: A buffer write with `en_i`=1 and `mst_i`=1 loads the register but leaves `bit_cnt_o` unchanged and does not pulse `scl_go_o`. A buffer write with `en_i`=0 or `mst_i`=0 leaves the register unchanged.
- R8: `bit_cnt_o` counts the shifts from 0 to 8. `byte_done_o` is high for exactly the one cycle in which the count becomes 8. After that, SCL edges do not change the register or the count until the next accepted data write.
- R9: Let cycle k be the first cycle with `mst_i`=0 after a cycle with `mst_i`=1. A strobe on either write port in cycle k+d, with d<20, raises `wr_gap_err_o` for one cycle in the following cycle. This holds whether or not the write is accepted. For d≥20 no error is raised.
- R10: A `start_req_i` in cycle k+d, where cycle k holds the most recent write strobe on either port, raises `start_gap_err_o` for one cycle in the following cycle when d<4. For d≥4 no error is raised.
- R11: The synchronous reset `rst_i` does four things. It clears the register, the count and both error flags. It leaves shifting disarmed. It sets both interval timers to the expired state, so a request right after reset is not flagged.
- R12: SCL is sampled through two registers. A change of `scl_i` first seen at clock edge n takes effect on the register and the count at edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Interface enable; gates both write ports |
| mst_i | input | 1 | Master mode |
| tx_mode_i | input | 1 | 1 = transmit (shift on SCL fall), 0 = receive (shift on SCL rise) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dsr_wr_i | input | 1 | Data register write strobe |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| wdata_i | input | 8 | Write data for either port |
| rd_sel_i | input | 1 | Read select: 0 = data register, 1 = buffer port |
| rdata_o | output | 8 | Read data |
| start_req_i | input | 1 | START/RESTART request strobe |
| sda_o | output | 1 | Serial data out (register bit 7) |
| scl_go_o | output | 1 | One-cycle request to begin SCL generation |
| bit_cnt_o | output | 4 | Bits shifted since the last data write |
| byte_done_o | output | 1 | One-cycle byte-complete pulse |
| wr_gap_err_o | output | 1 | Write too soon after leaving master mode |
| start_gap_err_o | output | 1 | START request too soon after a write |

## Verification
The hardest situations to reach are the exact edges of the two timing windows. Each one depends on the distance in cycles between two separate events. The bench sweeps that distance one cycle at a time across each threshold, and it uses writes with the enable low so that the register is left alone. Byte completion is reached through full 256-value sweeps in both directions. Each sweep is followed by surplus SCL edges and by blocked and buffer-port writes, all sitting at a count of 8.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
    localparam int SHIFT_W = 8;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);

    typedef struct packed {
        logic [SHIFT_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               armed;
        logic               done;
        logic               go;
    } core_state_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } scl_state_t;
endpackage

// File: rtl/i2c_scl_sampler.sv
module i2c_scl_sampler (
    input  logic clk_i,
    input  logic rst_i,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);
    import i2c_shift_pkg::*;

    scl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = scl_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rise_o = st_q.s1 & ~st_q.s2;
    assign fall_o = ~st_q.s1 & st_q.s2;
endmodule

// File: rtl/i2c_gap_monitor.sv
module i2c_gap_monitor #(
    parameter int GAP = 20
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic probe_i,
    output logic err_o
);
    localparam int AW = $clog2(GAP + 1);
    localparam logic [AW-1:0] LIMIT = AW'(GAP);

    typedef struct packed {
        logic [AW-1:0] age;
        logic          err;
    } gap_state_t;

    gap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = probe_i & (arm_i | (st_q.age < LIMIT));
        if (arm_i)
            st_d.age = AW'(1);
        else if (st_q.age < LIMIT)
            st_d.age = st_q.age + AW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.age <= LIMIT;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/i2c_shift_core.sv
module i2c_shift_core
    import i2c_shift_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               mst_i,
    input  logic               tx_mode_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               sda_i,
    input  logic               dsr_wr_i,
    input  logic               buf_wr_i,
    input  logic [SHIFT_W-1:0] wdata_i,
    output logic [SHIFT_W-1:0] shreg_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               done_o,
    output logic               go_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

    core_state_t st_d, st_q;
    logic dsr_ok, buf_ok, shift_now;

    always_comb begin
        dsr_ok    = dsr_wr_i & en_i;
        buf_ok    = buf_wr_i & en_i & mst_i & ~dsr_ok;
        shift_now = st_q.armed & (tx_mode_i ? fall_i : rise_i);

        st_d      = st_q;
        st_d.go   = 1'b0;
        st_d.done = 1'b0;

        if (dsr_ok) begin
            st_d.shreg = wdata_i;
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            st_d.go    = mst_i;
        end else if (buf_ok) begin
            st_d.shreg = wdata_i;
        end else if (shift_now) begin
            st_d.shreg = {st_q.shreg[SHIFT_W-2:0], tx_mode_i ? 1'b0 : sda_i};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST) begin
                st_d.armed = 1'b0;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign shreg_o = st_q.shreg;
    assign cnt_o   = st_q.cnt;
    assign done_o  = st_q.done;
    assign go_o    = st_q.go;
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
    parameter int MST_GAP   = 20,
    parameter int START_GAP = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       mst_i,
    input  logic       tx_mode_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       dsr_wr_i,
    input  logic       buf_wr_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_sel_i,
    output logic [7:0] rdata_o,
    input  logic       start_req_i,
    output logic       sda_o,
    output logic       scl_go_o,
    output logic [3:0] bit_cnt_o,
    output logic       byte_done_o,
    output logic       wr_gap_err_o,
    output logic       start_gap_err_o
);
    import i2c_shift_pkg::*;

    logic               rise, fall;
    logic [SHIFT_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               mst_d, mst_q;
    logic               mst_drop, any_wr;

    always_comb begin
        mst_d    = mst_i;
        mst_drop = mst_q & ~mst_i;
        any_wr   = dsr_wr_i | buf_wr_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) mst_q <= 1'b0;
        else       mst_q <= mst_d;
    end

    i2c_scl_sampler u_sampler (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .scl_i (scl_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    i2c_shift_core u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .mst_i    (mst_i),
        .tx_mode_i(tx_mode_i),
        .rise_i   (rise),
        .fall_i   (fall),
        .sda_i    (sda_i),
        .dsr_wr_i (dsr_wr_i),
        .buf_wr_i (buf_wr_i),
        .wdata_i  (wdata_i),
        .shreg_o  (shreg),
        .cnt_o    (cnt),
        .done_o   (byte_done_o),
        .go_o     (scl_go_o)
    );

    i2c_gap_monitor #(.GAP(MST_GAP)) u_wr_gap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .arm_i  (mst_drop),
        .probe_i(any_wr),
        .err_o  (wr_gap_err_o)
    );

    i2c_gap_monitor #(.GAP(START_GAP)) u_start_gap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .arm_i  (any_wr),
        .probe_i(start_req_i),
        .err_o  (start_gap_err_o)
    );

    assign rdata_o   = rd_sel_i ? '0 : shreg;
    assign sda_o     = shreg[SHIFT_W-1];
    assign bit_cnt_o = cnt;
endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic       mst_i,
    input logic       dsr_wr_i,
    input logic       buf_wr_i,
    input logic       start_req_i,
    input logic       scl_go_o,
    input logic [3:0] bit_cnt_o,
    input logic       byte_done_o,
    input logic       start_gap_err_o
);
    // R8
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_cnt_o <= 4'd8);

    // R8
    done_at_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_done_o |-> bit_cnt_o == 4'd8);

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_done_o |=> !byte_done_o);

    // R5
    go_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dsr_wr_i && en_i && mst_i) |=> scl_go_o);

    // R4
    go_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        scl_go_o |-> bit_cnt_o == 4'd0);

    // R3
    blocked_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && (dsr_wr_i || buf_wr_i)) |=> !scl_go_o);

    // R10
    start_same_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_req_i && (dsr_wr_i || buf_wr_i)) |=> start_gap_err_o);
endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .en_i           (en_i),
    .mst_i          (mst_i),
    .dsr_wr_i       (dsr_wr_i),
    .buf_wr_i       (buf_wr_i),
    .start_req_i    (start_req_i),
    .scl_go_o       (scl_go_o),
    .bit_cnt_o      (bit_cnt_o),
    .byte_done_o    (byte_done_o),
    .start_gap_err_o(start_gap_err_o)
);

// File: tb/i2c_byte_shifter_tb_top.sv
module i2c_byte_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i = 1'b0, mst_i = 1'b0, tx_mode_i = 1'b0;
    logic       scl_i = 1'b0, sda_i = 1'b0;
    logic       dsr_wr_i = 1'b0, buf_wr_i = 1'b0, rd_sel_i = 1'b0, start_req_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       sda_o, scl_go_o, byte_done_o, wr_gap_err_o, start_gap_err_o;
    logic [3:0] bit_cnt_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    i2c_byte_shifter dut_i (
        .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .mst_i(mst_i),
        .tx_mode_i(tx_mode_i), .scl_i(scl_i), .sda_i(sda_i),
        .dsr_wr_i(dsr_wr_i), .buf_wr_i(buf_wr_i), .wdata_i(wdata_i),
        .rd_sel_i(rd_sel_i), .rdata_o(rdata_o), .start_req_i(start_req_i),
        .sda_o(sda_o), .scl_go_o(scl_go_o), .bit_cnt_o(bit_cnt_o),
        .byte_done_o(byte_done_o), .wr_gap_err_o(wr_gap_err_o),
        .start_gap_err_o(start_gap_err_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_data(input logic [7:0] b);
        wdata_i = b; dsr_wr_i = 1'b1;
        @(negedge clk);
        dsr_wr_i = 1'b0;
    endtask

    task automatic wr_buf(input logic [7:0] b);
        wdata_i = b; buf_wr_i = 1'b1;
        @(negedge clk);
        buf_wr_i = 1'b0;
    endtask

    task automatic scl_to(input logic lvl);
        scl_i = lvl;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(int'(rdata_o), 0, "R11 rdata after reset");
        check(int'(bit_cnt_o), 0, "R11 count after reset");
        check(int'(byte_done_o), 0, "R11 done after reset");
        check(int'(wr_gap_err_o) + int'(start_gap_err_o), 0, "R11 errors after reset");

        // transmit sweep, master
        en_i = 1'b1; mst_i = 1'b1; tx_mode_i = 1'b1;
        for (int b = 0; b < 256; b++) begin
            wr_data(8'(b));
            check(int'(scl_go_o), 1, "R5 go pulse in master");
            check(int'(bit_cnt_o), 0, "R4 count cleared");
            check(int'(rdata_o), b, "R4 data loaded");
            for (int i = 0; i < 8; i++) begin
                check(int'(sda_o), (b >> (7 - i)) & 1, "R1 bit order");
                scl_to(1'b1);
                check(int'(bit_cnt_o), i, "R1 rise ignored in transmit");
                scl_i = 1'b0;
                @(negedge clk);
                check(int'(bit_cnt_o), i, "R12 not yet shifted");
                @(negedge clk);
                check(int'(bit_cnt_o), i + 1, "R1 count after fall");
                check(int'(byte_done_o), (i == 7) ? 1 : 0, "R8 done timing");
            end
            @(negedge clk);
            check(int'(byte_done_o), 0, "R8 done one cycle");
            check(int'(rdata_o), 0, "R1 register emptied");
        end

        // receive sweep, slave
        mst_i = 1'b0; tx_mode_i = 1'b0;
        for (int b = 0; b < 256; b++) begin
            en_i = 1'b1;
            wr_data(8'(~b));
            check(int'(scl_go_o), 0, "R5 no go in slave");
            for (int i = 0; i < 8; i++) begin
                sda_i = 1'((b >> (7 - i)) & 1);
                scl_i = 1'b1;
                @(negedge clk);
                check(int'(bit_cnt_o), i, "R12 not yet shifted");
                @(negedge clk);
                check(int'(bit_cnt_o), i + 1, "R2 count after rise");
                check(int'(byte_done_o), (i == 7) ? 1 : 0, "R8 done timing");
                scl_to(1'b0);
                check(int'(bit_cnt_o), i + 1, "R2 fall ignored in receive");
            end
            check(int'(rdata_o), b, "R2 received byte");
            sda_i = ~sda_i;
            scl_to(1'b1);
            scl_to(1'b0);
            check(int'(rdata_o), b, "R8 extra edge ignored");
            check(int'(bit_cnt_o), 8, "R8 count holds");
            en_i = 1'b0;
            check(int'(rdata_o), b, "R6 read with enable low");
            rd_sel_i = 1'b1;
            #1;
            check(int'(rdata_o), 0, "R6 buffer read is zero");
            rd_sel_i = 1'b0;
            wr_data(8'(~b));
            check(int'(rdata_o), b, "R3 blocked write data");
            check(int'(bit_cnt_o), 8, "R3 blocked write count");
            check(int'(scl_go_o), 0, "R3 blocked write go");
            en_i = 1'b1; mst_i = 1'b1;
            wr_buf(8'(~b));
            check(int'(rdata_o), (~b) & 255, "R7 buffer loads register");
            check(int'(bit_cnt_o), 8, "R7 buffer keeps count");
            check(int'(scl_go_o), 0, "R7 buffer no go");
            en_i = 1'b0;
            wr_buf(8'(b));
            check(int'(rdata_o), (~b) & 255, "R7 buffer blocked by enable");
            en_i = 1'b1; mst_i = 1'b0;
            wr_buf(8'(b));
            check(int'(rdata_o), (~b) & 255, "R7 buffer blocked in slave");
        end

        // write-after-master-drop window
        en_i = 1'b0; mst_i = 1'b1;
        repeat (25) @(negedge clk);
        for (int d = 0; d < 26; d++) begin
            mst_i = 1'b1;
            repeat (2) @(negedge clk);
            mst_i = 1'b0;
            repeat (d) @(negedge clk);
            if (d % 2 == 0) dsr_wr_i = 1'b1; else buf_wr_i = 1'b1;
            @(negedge clk);
            dsr_wr_i = 1'b0; buf_wr_i = 1'b0;
            check(int'(wr_gap_err_o), (d < 20) ? 1 : 0, "R9 write gap");
            @(negedge clk);
            check(int'(wr_gap_err_o), 0, "R9 error one cycle");
        end

        // start-after-write window
        mst_i = 1'b1;
        for (int d = 0; d < 8; d++) begin
            repeat (6) @(negedge clk);
            dsr_wr_i = 1'b1;
            if (d == 0) start_req_i = 1'b1;
            @(negedge clk);
            dsr_wr_i = 1'b0;
            if (d > 0) begin
                start_req_i = 1'b0;
                repeat (d - 1) @(negedge clk);
                start_req_i = 1'b1;
                @(negedge clk);
            end
            start_req_i = 1'b0;
            check(int'(start_gap_err_o), (d < 4) ? 1 : 0, "R10 start gap");
        end

        // reset mid-transfer
        en_i = 1'b1; mst_i = 1'b1; tx_mode_i = 1'b1;
        repeat (6) @(negedge clk);
        wr_data(8'hC3);
        scl_to(1'b1);
        scl_to(1'b0);
        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        start_req_i = 1'b1;
        @(negedge clk);
        start_req_i = 1'b0;
        check(int'(rdata_o), 0, "R11 register cleared");
        check(int'(bit_cnt_o), 0, "R11 count cleared");
        check(int'(start_gap_err_o), 0, "R11 timer expired after reset");
        scl_to(1'b1);
        scl_to(1'b0);
        check(int'(bit_cnt_o), 0, "R11 shifting disarmed");

        finish_run();
    end
endmodule